// File: doc/BRIEF.md
# Ethernet receive destination-address filter

This block decides whether a received frame is kept, based only on its 48-bit destination address. The address arrives as six bytes on a byte port, first byte first, each qualified by a valid strobe. A start marker travels with the first byte. Gaps in the strobe between bytes are allowed. One cycle after the sixth byte is taken, the block gives a single-cycle decision. The decision carries an accept flag and a code that names the rule which matched.

Software sets the filter up through a one-word write port. The port reaches three things: a 16-entry exact-address table, a 512-bit multicast hash bitmap and a mode word. Each frame is judged against the settings that were in place when its start marker arrived. The multicast hash index comes from a CRC-32 run over the address bit by bit, least significant bit first.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the decision outputs are low and zero. Every exact-table half reads 0xFFFF, the hash bitmap is all zero and the mode word is zero, so no address is accepted.
- R2: A byte is taken when `in_valid` is high and either `in_sof` is high or a frame is open. `in_sof` with `in_valid` always restarts at byte 0. Bytes arriving with no open frame, and bytes beyond the sixth, are ignored. Idle cycles between bytes are allowed.
- R3: `dec_valid` pulses for exactly one cycle, in the cycle after the sixth byte is taken. Outside that pulse `dec_accept` is 0 and `dec_reason` is 0. `dec_accept` is 1 exactly when `dec_reason` is nonzero. Code 0 means rejected.
- R4: With mode bit 0x0001 set, every address is accepted with reason 1.
- R5: An address of all ones is broadcast. It is accepted with reason 2 only when mode bit 0x0004 is set. Neither the exact table, nor accept-all-multicast, nor the hash ever accepts it.
- R6: When all mode bits of 0xE040 are set, a non-broadcast address equal to any table entry is accepted with reason 3. Entries are written with `wr_sel`=0 and `wr_idx[5:2]` = entry. `wr_idx[1:0]` = half 0..2 holds address bytes 2h (bits 7:0) and 2h+1 (bits 15:8). Half code 3 is ignored.
- R7: With mode bit 0x0002, an address whose first byte has bit 0 set (multicast) is accepted with reason 4. A unicast address is not.
- R8: With mode bit 0x0010, a multicast address is accepted with reason 5 when its hash bit is set. The CRC uses the reflected polynomial 0xEDB88320, is preset to all ones, takes bits LSB first and has no final inversion. The index is CRC bits 31..23. Bitmap bit i is bit i[3:0] of word i[8:4], written with `wr_sel`=1 and `wr_idx[4:0]`.
- R9: When several rules match, the order is accept-all, broadcast, exact match, all-multicast, hash. The first rule that matches sets the reason.
- R10: The mode word is written with `wr_sel`=2. A write made before a frame's start cycle applies to that frame. A write made in the start cycle or later applies only from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Target: 0 exact table, 1 hash bitmap, 2 mode |
| wr_idx | input | 6 | Word index inside the target |
| wr_data | input | 16 | Write data |
| in_sof | input | 1 | First address byte marker |
| in_valid | input | 1 | Address byte strobe |
| in_byte | input | 8 | Address byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | Rule that matched, 0 when rejected |

## Verification
The state inside this block is a byte position, a running CRC, per-entry match flags and the snapshot tables. A wrong byte position shows up at once: the decision pulse comes early, late or twice, and this is visible on the first frame. A fault in the CRC or in the per-entry match flags gives a wrong reason code, but only on a frame whose address falls on the faulty path. For that reason, exact-match hits are tested in both the first and the last table entry, and hash hits are paired with unicast and different-index misses. A snapshot fault appears only on the frame that follows a configuration write. So the start-cycle write and the mid-frame write are each checked on two frames in a row.

// File: rtl/raf_pkg.sv
package raf_pkg;
  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_ALL     = 3'd1,
    RSN_BCAST   = 3'd2,
    RSN_PERFECT = 3'd3,
    RSN_ALLMC   = 3'd4,
    RSN_HASH    = 3'd5
  } reason_e;

  localparam logic [15:0] MODE_ALL   = 16'h0001;
  localparam logic [15:0] MODE_ALLMC = 16'h0002;
  localparam logic [15:0] MODE_BCAST = 16'h0004;
  localparam logic [15:0] MODE_HASH  = 16'h0010;
  localparam logic [15:0] MODE_OWN   = 16'hE040;

  localparam logic [1:0] SEL_CAM  = 2'd0;
  localparam logic [1:0] SEL_HASH = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;
endpackage

// File: rtl/raf_crc_byte.sv
// One address byte through the reflected CRC, one unrolled step per bit.
module raf_crc_byte #(
  parameter int          CRC_W = 32,
  parameter logic [31:0] POLY  = 32'hEDB88320
)(
  input  logic [CRC_W-1:0] crc_i,
  input  logic [7:0]       data_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] stage [0:8];
  assign stage[0] = crc_i;

  for (genvar b = 0; b < 8; b++) begin : g_bit
    logic fb;
    assign fb           = stage[b][0] ^ data_i[b];
    assign stage[b+1]   = (stage[b] >> 1) ^ (fb ? POLY[CRC_W-1:0] : '0);
  end

  assign crc_o = stage[8];
endmodule

// File: rtl/raf_cam.sv
// Exact-address table: shadow written by software, snapshot taken at frame start,
// per-entry running match flags updated byte by byte.
module raf_cam #(
  parameter int N_ENT  = 16,
  parameter int WORD_W = 16,
  parameter int HALVES = 3,
  parameter int POS_W  = 3,
  localparam int ENT_W = $clog2(N_ENT)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ENT_W+1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              load,
  input  logic              step,
  input  logic [POS_W-1:0]  pos,
  input  logic [7:0]        byte_i,
  output logic              hit_o
);
  logic [WORD_W-1:0] shd [N_ENT][HALVES];
  logic [WORD_W-1:0] act [N_ENT][HALVES];
  logic [N_ENT-1:0]  match_q, match_nx;

  logic [ENT_W-1:0] w_ent;
  logic [1:0]       w_half;
  assign w_ent  = wr_idx[ENT_W+1:2];
  assign w_half = wr_idx[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < N_ENT; e++)
        for (int h = 0; h < HALVES; h++) begin
          shd[e][h] <= '1;
          act[e][h] <= '1;
        end
      match_q <= '0;
    end else begin
      if (wr_en && (int'(w_half) < HALVES) && (int'(w_ent) < N_ENT))
        shd[w_ent][w_half] <= wr_data;
      if (load)
        for (int e = 0; e < N_ENT; e++)
          for (int h = 0; h < HALVES; h++)
            act[e][h] <= shd[e][h];
      if (step)
        match_q <= match_nx;
    end
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [WORD_W-1:0] hw;
    logic [7:0]        bsel;
    assign hw   = load ? shd[e][pos[POS_W-1:1]] : act[e][pos[POS_W-1:1]];
    assign bsel = pos[0] ? hw[15:8] : hw[7:0];
    assign match_nx[e] = ((pos == '0) ? 1'b1 : match_q[e]) & (byte_i == bsel);
  end

  assign hit_o = |match_nx;
endmodule

// File: rtl/raf_hash_bank.sv
// Multicast hash bitmap: word-written shadow, frame-start snapshot, single-bit lookup.
module raf_hash_bank #(
  parameter int IDX_BITS = 9,
  parameter int WORD_W   = 16,
  localparam int N_WORDS = (1 << IDX_BITS) / WORD_W,
  localparam int WSEL_W  = $clog2(N_WORDS),
  localparam int BSEL_W  = $clog2(WORD_W)
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [WSEL_W-1:0]   wr_word,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                load,
  input  logic [IDX_BITS-1:0] lookup,
  output logic                hit_o
);
  logic [WORD_W-1:0] shd [N_WORDS];
  logic [WORD_W-1:0] act [N_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < N_WORDS; w++) begin
        shd[w] <= '0;
        act[w] <= '0;
      end
    end else begin
      if (wr_en)
        shd[wr_word] <= wr_data;
      if (load)
        for (int w = 0; w < N_WORDS; w++)
          act[w] <= shd[w];
    end
  end

  assign hit_o = act[lookup[IDX_BITS-1:BSEL_W]][lookup[BSEL_W-1:0]];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import raf_pkg::*;
#(
  parameter int          N_ENT      = 16,
  parameter int          HASH_BITS  = 9,
  parameter int          WORD_W     = 16,
  parameter int          ADDR_BYTES = 6,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320,
  localparam int ENT_W      = $clog2(N_ENT),
  localparam int HASH_WORDS = (1 << HASH_BITS) / WORD_W,
  localparam int HW_W       = $clog2(HASH_WORDS),
  localparam int IDX_W      = (ENT_W + 2 > HW_W) ? ENT_W + 2 : HW_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              in_sof,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [2:0]        dec_reason
);
  localparam int POS_W  = $clog2(ADDR_BYTES);
  localparam int HALVES = ADDR_BYTES * 8 / WORD_W;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

  // byte framing
  logic             open_q;
  logic [POS_W-1:0] cnt_q, pos;
  logic             take, last, load;

  assign take = in_valid && (in_sof || open_q);
  assign pos  = in_sof ? '0 : cnt_q;
  assign last = take && (pos == LAST_POS);
  assign load = in_valid && in_sof;

  // running CRC
  logic [31:0] crc_q, crc_in, crc_nx;
  assign crc_in = in_sof ? '1 : crc_q;

  raf_crc_byte #(.CRC_W(32), .POLY(CRC_POLY)) u_crc (
    .crc_i (crc_in),
    .data_i(in_byte),
    .crc_o (crc_nx)
  );

  // address class flags
  logic bc_q, bc_nx, mc_q;
  assign bc_nx = ((pos == '0) ? 1'b1 : bc_q) & (&in_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      crc_q  <= '1;
      bc_q   <= 1'b0;
      mc_q   <= 1'b0;
    end else if (take) begin
      open_q <= !last;
      cnt_q  <= pos + 1'b1;
      crc_q  <= crc_nx;
      bc_q   <= bc_nx;
      if (pos == '0) mc_q <= in_byte[0];
    end
  end

  // mode word: shadow plus frame snapshot
  logic [WORD_W-1:0] mode_sh, mode_act;
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_sh  <= '0;
      mode_act <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_MODE) mode_sh <= wr_data;
      if (load) mode_act <= mode_sh;
    end
  end

  // tables
  logic cam_hit, hash_hit;

  raf_cam #(.N_ENT(N_ENT), .WORD_W(WORD_W), .HALVES(HALVES), .POS_W(POS_W)) u_cam (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en && wr_sel == SEL_CAM),
    .wr_idx (wr_idx[ENT_W+1:0]),
    .wr_data(wr_data),
    .load   (load),
    .step   (take),
    .pos    (pos),
    .byte_i (in_byte),
    .hit_o  (cam_hit)
  );

  raf_hash_bank #(.IDX_BITS(HASH_BITS), .WORD_W(WORD_W)) u_hash (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en && wr_sel == SEL_HASH),
    .wr_word(wr_idx[HW_W-1:0]),
    .wr_data(wr_data),
    .load   (load),
    .lookup (crc_nx[31 -: HASH_BITS]),
    .hit_o  (hash_hit)
  );

  // priority decision, evaluated on the last byte
  reason_e rsn_nx;
  always_comb begin
    rsn_nx = RSN_NONE;
    if ((mode_act & MODE_ALL) != '0)
      rsn_nx = RSN_ALL;
    else if (bc_nx)
      rsn_nx = ((mode_act & MODE_BCAST) != '0) ? RSN_BCAST : RSN_NONE;
    else if (((mode_act & MODE_OWN) == MODE_OWN) && cam_hit)
      rsn_nx = RSN_PERFECT;
    else if (((mode_act & MODE_ALLMC) != '0) && mc_q)
      rsn_nx = RSN_ALLMC;
    else if (((mode_act & MODE_HASH) != '0) && mc_q && hash_hit)
      rsn_nx = RSN_HASH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= RSN_NONE;
    end else begin
      dec_valid <= last;
      if (last) begin
        dec_reason <= rsn_nx;
        dec_accept <= (rsn_nx != RSN_NONE);
      end else begin
        dec_reason <= RSN_NONE;
        dec_accept <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/raf_checker.sv
module raf_checker #(
  parameter int ADDR_BYTES = 6
)(
  input logic       clk,
  input logic       rst,
  input logic       in_sof,
  input logic       in_valid,
  input logic [7:0] in_byte,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic [2:0] dec_reason
);
  logic ck_open, ck_bc, ck_bc_fin, ck_mc, ck_mc_fin;
  int   ck_n;
  logic take_c, sixth_c;
  int   n_c;

  assign take_c  = in_valid && (in_sof || ck_open);
  assign n_c     = in_sof ? 0 : ck_n;
  assign sixth_c = take_c && (n_c == ADDR_BYTES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_open <= 1'b0; ck_n <= 0;
      ck_bc <= 1'b0; ck_mc <= 1'b0; ck_bc_fin <= 1'b0; ck_mc_fin <= 1'b0;
    end else if (take_c) begin
      ck_open <= !sixth_c;
      ck_n    <= n_c + 1;
      ck_bc   <= ((n_c == 0) ? 1'b1 : ck_bc) && (in_byte == 8'hFF);
      if (n_c == 0) ck_mc <= in_byte[0];
      if (sixth_c) begin
        ck_bc_fin <= ck_bc && (in_byte == 8'hFF);
        ck_mc_fin <= ck_mc;
      end
    end
  end

  AST_DEC_AFTER_SIXTH: assert property (@(posedge clk) disable iff (rst)
    sixth_c |=> dec_valid); // R3
  AST_NO_STRAY_DEC: assert property (@(posedge clk) disable iff (rst)
    !sixth_c |=> !dec_valid); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!dec_accept && dec_reason == 3'd0)); // R3
  AST_BCAST_CODE_ONLY_BCAST: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_reason == 3'd2) |-> ck_bc_fin); // R5
  AST_PERFECT_NOT_BCAST: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_reason == 3'd3) |-> !ck_bc_fin); // R5
  AST_MCAST_CODES: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && (dec_reason == 3'd4 || dec_reason == 3'd5)) |-> (ck_mc_fin && !ck_bc_fin)); // R7
endmodule

bind rx_addr_filter raf_checker #(.ADDR_BYTES(ADDR_BYTES)) u_raf_checker (
  .clk       (clk),
  .rst       (rst),
  .in_sof    (in_sof),
  .in_valid  (in_valid),
  .in_byte   (in_byte),
  .dec_valid (dec_valid),
  .dec_accept(dec_accept),
  .dec_reason(dec_reason)
);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [5:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic        in_sof = 1'b0, in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        dec_valid, dec_accept;
  logic [2:0]  dec_reason;

  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;

  // frame-time write injection
  bit          mid_en = 1'b0;
  int          mid_at = 0;
  logic [1:0]  mid_sel;
  logic [5:0]  mid_idx;
  logic [15:0] mid_data;

  always #2 clk = ~clk;

  rx_addr_filter dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .in_sof(in_sof), .in_valid(in_valid), .in_byte(in_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [5:0] i, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_idx = i; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_entry(input int e, input logic [47:0] a);
    for (int h = 0; h < 3; h++) cfg(2'd0, {4'(e), 2'(h)}, a[16*h +: 16]);
  endtask

  function automatic logic [8:0] hidx(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < 8; b++) begin
        logic f = c[0] ^ a[8*k + b];
        c = c >> 1;
        if (f) c = c ^ 32'hEDB88320;
      end
    return c[31:23];
  endfunction

  task automatic set_hash_bit(input logic [47:0] a);
    logic [8:0] i = hidx(a);
    cfg(2'd1, {1'b0, i[8:4]}, 16'(1) << i[3:0]);
  endtask

  task automatic put_byte(input logic [7:0] b, input logic s, input int k);
    in_valid = 1'b1; in_sof = s; in_byte = b;
    if (mid_en && mid_at == k) begin
      wr_en = 1'b1; wr_sel = mid_sel; wr_idx = mid_idx; wr_data = mid_data;
    end
    tick();
    in_valid = 1'b0; in_sof = 1'b0; wr_en = 1'b0;
  endtask

  // Sends one address; checks the pulse, its code and that it lasts one cycle.
  task automatic frame(input string tag, input logic [47:0] a, input int exp, input int gap);
    for (int k = 0; k < 6; k++) begin
      put_byte(a[8*k +: 8], k == 0, k);
      if (k < 5) for (int g = 0; g < gap; g++) tick();
    end
    check({tag, " valid"}, dec_valid, 1);
    check({tag, " reason"}, dec_reason, exp);
    check({tag, " accept"}, dec_accept, exp != 0);
    tick();
    check({tag, " pulse width"}, dec_valid, 0);
  endtask

  localparam logic [47:0] BC  = '1;
  localparam logic [47:0] UC  = 48'h55_44_33_22_11_00;
  localparam logic [47:0] UC2 = 48'h0A_0B_0C_0D_0E_02;
  localparam logic [47:0] MC  = 48'hFB_00_00_5E_00_01;
  localparam logic [47:0] MC2 = 48'h77_66_55_44_33_03;

  task automatic t_reset();
    check("R1 valid after reset", dec_valid, 0);
    check("R1 reason after reset", dec_reason, 0);
    frame("R1 bcast with reset tables", BC, 0, 0);
    frame("R1 unicast with reset tables", UC, 0, 0);
    cfg(2'd2, 6'd0, 16'hE040);
    frame("R1 reset entries miss broadcast", BC, 0, 0);
    cfg(2'd2, 6'd0, 16'h0010);
    frame("R1 hash bitmap cleared", MC, 0, 0);
  endtask

  task automatic t_accept_all();
    cfg(2'd2, 6'd0, 16'h0001);
    frame("R4 unicast", UC, 1, 0);
    frame("R4 broadcast", BC, 1, 1);
  endtask

  task automatic t_bcast();
    cfg(2'd2, 6'd0, 16'h0004);
    frame("R5 broadcast on", BC, 2, 0);
    cfg(2'd1, 6'd31, 16'hFFFF);
    for (int w = 0; w < 32; w++) cfg(2'd1, 6'(w), 16'hFFFF);
    cfg(2'd2, 6'd0, 16'hE052);
    frame("R5 broadcast off, other rules on", BC, 0, 0);
    for (int w = 0; w < 32; w++) cfg(2'd1, 6'(w), 16'h0000);
  endtask

  task automatic t_perfect();
    set_entry(0, UC);
    set_entry(15, MC2);
    cfg(2'd2, 6'd0, 16'hE040);
    frame("R6 entry 0", UC, 3, 0);
    frame("R6 entry 15", MC2, 3, 2);
    frame("R6 miss", UC2, 0, 0);
    cfg(2'd0, {4'd0, 2'd3}, 16'h0000);
    frame("R6 half code 3 ignored", UC, 3, 0);
    cfg(2'd2, 6'd0, 16'h6040);
    frame("R6 partial own mode", UC, 0, 0);
    set_entry(0, BC);
    set_entry(15, BC);
  endtask

  task automatic t_allmc();
    cfg(2'd2, 6'd0, 16'h0002);
    frame("R7 multicast", MC, 4, 0);
    frame("R7 unicast", UC, 0, 0);
  endtask

  task automatic t_hash();
    cfg(2'd2, 6'd0, 16'h0010);
    set_hash_bit(MC);
    frame("R8 hash hit", MC, 5, 0);
    frame("R8 other multicast", MC2, (hidx(MC2) == hidx(MC)) ? 5 : 0, 0);
    set_hash_bit(UC);
    frame("R8 unicast never hashed", UC, 0, 0);
    for (int w = 0; w < 32; w++) cfg(2'd1, 6'(w), 16'h0000);
  endtask

  task automatic t_priority();
    set_entry(1, MC);
    set_hash_bit(MC);
    cfg(2'd2, 6'd0, 16'hE056);
    frame("R9 exact over multicast rules", MC, 3, 0);
    cfg(2'd2, 6'd0, 16'h0016);
    frame("R9 all-multicast over hash", MC, 4, 0);
    cfg(2'd2, 6'd0, 16'h0014);
    frame("R9 hash last", MC, 5, 0);
    cfg(2'd2, 6'd0, 16'hE056);
    frame("R9 broadcast over exact", BC, 2, 0);
    cfg(2'd2, 6'd0, 16'hE057);
    frame("R9 accept-all first", MC, 1, 0);
  endtask

  task automatic t_framing();
    cfg(2'd2, 6'd0, 16'h0001);
    for (int k = 0; k < 8; k++) begin
      put_byte(8'h10 + 8'(k), 1'b0, 9);
      check("R2 stray byte no decision", dec_valid, 0);
    end
    for (int k = 0; k < 3; k++) put_byte(UC2[8*k +: 8], k == 0, 9);
    check("R2 partial frame silent", dec_valid, 0);
    frame("R2 restart on sof", UC, 1, 0);
    for (int k = 0; k < 4; k++) begin
      put_byte(8'hAA, 1'b0, 9);
      check("R3 bytes past sixth ignored", dec_valid, 0);
    end
    frame("R2 idle gaps", UC2, 1, 3);
  endtask

  task automatic t_write_timing();
    cfg(2'd2, 6'd0, 16'h0001);
    mid_en = 1'b1; mid_at = 2; mid_sel = 2'd2; mid_idx = 6'd0; mid_data = 16'h0000;
    frame("R10 mid-frame write deferred", UC, 1, 0);
    mid_en = 1'b0;
    frame("R10 write applies next frame", UC, 0, 0);
    mid_en = 1'b1; mid_at = 0; mid_data = 16'h0001;
    frame("R10 start-cycle write deferred", UC, 0, 0);
    mid_en = 1'b0;
    frame("R10 start-cycle write then applies", UC, 1, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_accept_all();
    t_bcast();
    t_perfect();
    t_allmc();
    t_hash();
    t_priority();
    t_framing();
    t_write_timing();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule